// File: doc/BRIEF.md
# Cascadable Carry-Select Adder Slice

This block adds two binary operands with a carry-select structure. Each ten-bit slice is made of ten one-bit cells arranged in two groups of five. Every cell works out its sum bit and carry for both possible incoming carries at once. The two chains run side by side: one is seeded with a zero carry and the other with a one. The real carry is resolved only at each group boundary, where it picks the precomputed results of the group above. Slices cascade through their boundary carry, and a parameter sets how many slices make up the full operand width.

The output can be taken in two ways. In direct mode the sum is driven straight from the adder, and no register is in the path. In accumulate mode the adder's first operand is replaced by an internal register. On each rising clock edge that register loads its own value plus operand B plus the carry-in. A synchronous reset clears the register to zero.

Top module: `csa_adder_top`

## Requirements
- R1: With `accMode` low, `sumOut` equals `(opA + opB + carryIn) mod 2^WIDTH` in the same cycle.
- R2: With `accMode` low, `carryOut` equals bit WIDTH of `opA + opB + carryIn`. This is the carry out of the topmost slice.
- R3: With `accMode` high and `rst` low, each rising edge loads the register with `(acc + opB + carryIn) mod 2^WIDTH`. `sumOut` shows the register value.
- R4: A rising edge with `rst` high clears the register to zero. It shows as `sumOut == 0` once `accMode` is high.
- R5: While `accMode` is low, the register keeps its value over any number of edges.
- R6: With `accMode` high, `opA` has no effect on `sumOut` or on the value loaded into the register.
- R7: A carry entering bit 0 ripples correctly through every group and slice boundary. For example, all-ones plus zero with `carryIn = 1` gives a sum of 0 and `carryOut = 1`.
- R8: With `accMode` high, `carryOut` is bit WIDTH of `acc + opB + carryIn`, taken before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the register |
| accMode | input | 1 | 0: direct sum, 1: accumulate |
| opA | input | WIDTH | First operand, used only in direct mode |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Sum, or the register value in accumulate mode |
| carryOut | output | 1 | Carry out of the top slice |

## Verification
A wrong chain selection at a group or slice boundary corrupts only the bits above that boundary. In direct mode it shows at `sumOut` and `carryOut` in the same cycle. The bench therefore drives operands whose carries cross every boundary, with both carry-in values. In accumulate mode, a wrong register update is carried into every later value. It shows at `sumOut` one cycle after the faulty edge and stays visible from then on.

// File: rtl/csa_pkg.sv
package csa_pkg;
  typedef struct packed {
    logic clearAcc;
    logic loadAcc;
    logic bypass;
  } csa_strobe_t;
endpackage

// File: rtl/csa_cell.sv
module csa_cell (
  input  logic a,
  input  logic b,
  input  logic c0,
  input  logic c1,
  output logic s0,
  output logic s1,
  output logic co0,
  output logic co1
);
  always_comb begin
    s0  = a ^ b ^ c0;
    s1  = a ^ b ^ c1;
    co0 = (a & b) | (a & c0) | (b & c0);
    co1 = (a & b) | (a & c1) | (b & c1);
  end
endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int GROUP_W = 5
) (
  input  logic [GROUP_W-1:0] a,
  input  logic [GROUP_W-1:0] b,
  input  logic               groupCin,
  output logic [GROUP_W-1:0] sum,
  output logic               groupCout
);
  logic [GROUP_W:0]   chain0;
  logic [GROUP_W:0]   chain1;
  logic [GROUP_W-1:0] sumZero;
  logic [GROUP_W-1:0] sumOne;

  assign chain0[0] = 1'b0;
  assign chain1[0] = 1'b1;

  for (genvar i = 0; i < GROUP_W; i++) begin : g_cell
    csa_cell u_cell (
      .a   (a[i]),
      .b   (b[i]),
      .c0  (chain0[i]),
      .c1  (chain1[i]),
      .s0  (sumZero[i]),
      .s1  (sumOne[i]),
      .co0 (chain0[i+1]),
      .co1 (chain1[i+1])
    );
  end

  always_comb begin
    sum       = groupCin ? sumOne : sumZero;
    groupCout = groupCin ? chain1[GROUP_W] : chain0[GROUP_W];
  end

  // A carry present with an assumed zero carry-in must also be present with an assumed one (R2, R7)
  always_comb begin
    assert_chain_order_R2: assert ((chain0 & ~chain1) == '0)
      else $error("zero-seeded chain carries where one-seeded chain does not");
  end
endmodule

// File: rtl/csa_slice.sv
module csa_slice #(
  parameter int SLICE_W = 10,
  parameter int GROUP_W = 5
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               sliceCin,
  output logic [SLICE_W-1:0] sum,
  output logic               sliceCout
);
  localparam int NUM_GROUPS = SLICE_W / GROUP_W;

  logic [NUM_GROUPS:0] groupCarry;

  assign groupCarry[0] = sliceCin;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    csa_group #(.GROUP_W(GROUP_W)) u_group (
      .a         (a[g*GROUP_W +: GROUP_W]),
      .b         (b[g*GROUP_W +: GROUP_W]),
      .groupCin  (groupCarry[g]),
      .sum       (sum[g*GROUP_W +: GROUP_W]),
      .groupCout (groupCarry[g+1])
    );
  end

  assign sliceCout = groupCarry[NUM_GROUPS];
endmodule

// File: rtl/csa_control.sv
module csa_control
  import csa_pkg::*;
(
  input  logic        rst,
  input  logic        accMode,
  output csa_strobe_t ctrl
);
  always_comb begin
    ctrl.clearAcc = rst;
    ctrl.loadAcc  = accMode & ~rst;
    ctrl.bypass   = ~accMode;
  end
endmodule

// File: rtl/csa_datapath.sv
module csa_datapath
  import csa_pkg::*;
#(
  parameter int SLICE_W    = 10,
  parameter int GROUP_W    = 5,
  parameter int NUM_SLICES = 2,
  localparam int WIDTH     = SLICE_W * NUM_SLICES
) (
  input  logic             clk,
  input  csa_strobe_t      ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  logic [WIDTH-1:0]    accReg;
  logic [WIDTH-1:0]    adderA;
  logic [WIDTH-1:0]    adderSum;
  logic [NUM_SLICES:0] sliceCarry;

  assign adderA        = ctrl.bypass ? opA : accReg;
  assign sliceCarry[0] = carryIn;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    csa_slice #(.SLICE_W(SLICE_W), .GROUP_W(GROUP_W)) u_slice (
      .a         (adderA[s*SLICE_W +: SLICE_W]),
      .b         (opB[s*SLICE_W +: SLICE_W]),
      .sliceCin  (sliceCarry[s]),
      .sum       (adderSum[s*SLICE_W +: SLICE_W]),
      .sliceCout (sliceCarry[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (ctrl.clearAcc)     accReg <= '0;
    else if (ctrl.loadAcc) accReg <= adderSum;
  end

  assign sumOut   = ctrl.bypass ? adderSum : accReg;
  assign carryOut = sliceCarry[NUM_SLICES];

  assert_acc_load_R3: assert property (@(posedge clk) disable iff (ctrl.clearAcc)
    ctrl.loadAcc |=> accReg == $past(adderSum))
    else $error("register did not take the adder result");

  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (ctrl.clearAcc)
    (!ctrl.loadAcc) |=> $stable(accReg))
    else $error("register changed in direct mode");

  assert_acc_clear_R4: assert property (@(posedge clk) disable iff (ctrl.clearAcc)
    $fell(ctrl.clearAcc) |-> accReg == '0)
    else $error("register not zero after reset");

  assert_out_select_R6: assert property (@(posedge clk) disable iff (ctrl.clearAcc)
    (!ctrl.bypass) |-> sumOut == accReg)
    else $error("accumulate mode output is not the register");
endmodule

// File: rtl/csa_adder_top.sv
module csa_adder_top
  import csa_pkg::*;
#(
  parameter int SLICE_W    = 10,
  parameter int GROUP_W    = 5,
  parameter int NUM_SLICES = 2,
  localparam int WIDTH     = SLICE_W * NUM_SLICES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  csa_strobe_t ctrl;

  csa_control u_control (
    .rst     (rst),
    .accMode (accMode),
    .ctrl    (ctrl)
  );

  csa_datapath #(
    .SLICE_W    (SLICE_W),
    .GROUP_W    (GROUP_W),
    .NUM_SLICES (NUM_SLICES)
  ) u_datapath (
    .clk      (clk),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );
endmodule

// File: tb/test_csa_adder_top.sv
`timescale 1ns/1ps
module test_csa_adder_top;
  localparam int W = 20;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         accMode = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  int testCount = 0;
  int failCount = 0;
  logic [W-1:0] model = '0;

  always #2.5 clk = ~clk;

  csa_adder_top i_csa_adder_top (
    .clk(clk), .rst(rst), .accMode(accMode), .opA(opA), .opB(opB),
    .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut)
  );

  function automatic logic [W:0] refAdd(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic combCase(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                          input string req);
    logic [W:0] r;
    opA = a; opB = b; carryIn = c;
    #1;
    r = refAdd(a, b, c);
    check({req, " R1 sum"}, 64'(sumOut), 64'(r[W-1:0]));
    check({req, " R2 carry"}, 64'(carryOut), 64'(r[W]));
  endtask

  task automatic accStep(input logic [W-1:0] b, input logic c, input logic [W-1:0] junkA);
    logic [W:0] r;
    opB = b; carryIn = c; opA = junkA;
    #1;
    r = refAdd(model, b, c);
    check("R8 carry before edge", 64'(carryOut), 64'(r[W]));
    @(posedge clk); #1;
    model = r[W-1:0];
    check("R3 register update", 64'(sumOut), 64'(model));
  endtask

  initial begin
    #1000000;
    failCount++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    check("R4 reset clears", 64'(sumOut), 64'd0);

    rst = 1'b0;
    accMode = 1'b0;
    // R7 carry rippling across every group and slice boundary
    combCase(ONES, '0, 1'b1, "R7 ones+0+1");
    combCase(ONES, ONES, 1'b1, "R7 ones+ones+1");
    combCase(ONES, ONES, 1'b0, "R7 ones+ones+0");
    combCase('0, '0, 1'b0, "R1 zero");
    combCase(W'(20'h0001F), W'(20'h00001), 1'b0, "R7 group edge");
    combCase(W'(20'h003FF), '0, 1'b1, "R7 slice edge");
    for (int i = 0; i < 200; i++)
      combCase(W'($urandom()), W'($urandom()), 1'(i & 1), "random");

    // accumulate from zero
    @(posedge clk); #1;
    accMode = 1'b1;
    #1;
    check("R4 register still zero", 64'(sumOut), 64'd0);
    accStep(ONES, 1'b1, W'($urandom()));
    accStep(ONES, 1'b1, W'($urandom()));
    for (int i = 0; i < 40; i++)
      accStep(W'($urandom()), 1'($urandom()), W'($urandom()));

    // R6: opA changes with opB zero must not move the register
    for (int i = 0; i < 4; i++) begin
      opA = W'($urandom()); opB = '0; carryIn = 1'b0;
      @(posedge clk); #1;
      check("R6 opA ignored", 64'(sumOut), 64'(model));
    end

    // R5: direct mode leaves the register alone
    accMode = 1'b0;
    for (int i = 0; i < 5; i++) begin
      opA = W'($urandom()); opB = W'($urandom()); carryIn = 1'($urandom());
      @(posedge clk); #1;
    end
    accMode = 1'b1;
    #1;
    check("R5 register held", 64'(sumOut), 64'(model));

    // R4: reset in the middle of accumulation
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    model = '0;
    check("R4 reset mid-run", 64'(sumOut), 64'd0);
    accStep(W'(20'h12345), 1'b0, ONES);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule